// File: doc/BRIEF.md
# Toggle-Point Line Pulse Generator

This block produces the line-rate control waveforms for an image sensor. A pixel counter runs across each line. A table of 32 programmable toggle points is scanned in index order, one expected point at a time. When the counter reaches the compare value of the current point, all eight internal pulses take the levels held in that point's polarity word. The scan then moves to the next point. The eight pulses reach ten output pins through a per-pin selector. The five lowest pins can carry the pixel clock instead of a pulse. Each pin has its own output enable and signal enable.

In master mode the counter wraps at a programmed line length. In slave mode an external line-sync input restarts the line. A single write port loads a staging copy of every setting. The staging copy moves into the working copy only at the start of a line, or on every cycle while the generator is disabled, so no waveform changes in the middle of a line.

The toggle-point scan is a three-state machine:
- **IDLE**: the generator is disabled.
- **SCAN**: a point is still expected on this line.
- **DONE**: no further point can fire on this line.

The transitions are:
- **disable**: any state goes to IDLE.
- **line start**: any enabled state goes to SCAN.
- **exhaust**: IDLE or SCAN goes to DONE when the current point is disabled, or when the last enabled point has just fired.
- **proceed**: IDLE goes to SCAN otherwise.

Top module: `tpg_line_pulse_gen`

## Requirements
- R1: While the enable bit (write kind 0, data bit 0) is clear, every internal pulse is held at 0 and the counter is held at 0. Setting the bit takes effect on the next cycle. Clearing it also takes effect on the next cycle, without waiting for a line start.
- R2: In master mode (kind 0, data bit 1 = 1), the counter counts 0 up to the line length (kind 1, data bits 11:0) and then returns to 0. The line period is therefore length+1 cycles.
- R3: In slave mode, a high line_sync on a clock edge returns the counter to 0 and the scan to point 0. The line length has no effect. Without a sync, the counter stops at its maximum value.
- R4: Toggle point i is written with kind 2 at index i: data bits 11:0 hold the compare value and data bit 12 holds the enable. A point fires only when it is the current scan point, it is enabled, and its value equals the counter. A disabled point never fires and ends the scan for that line.
- R5: The points are taken in index order, each at most once per line. At each line start the scan returns to point 0, and every pulse keeps its level until it is changed by a later firing point.
- R6: The polarity word of point i (kind 3, data bits 7:0, bit k for pulse k) gives the level that pulse k takes when point i fires. Pulses are registered: a match with the counter at N shows on the pins one cycle after the counter holds N. On cycles without a firing point, the pulses do not change.
- R7: Pin p (kind 4, index p) carries the pulse whose number is in data bits 2:0. A pin write with an index of 10 or above is ignored.
- R8: On pins 0 to 4, data bit 3 of the pin word selects the pixel clock (the clk input) in place of the pulse. On pins 5 to 9 that bit has no effect.
- R9: A pin drives its selected signal only when both its output enable (data bit 4) and its signal enable (data bit 5) are set. pin_oe follows the output enable. A pin whose output enable is set but whose signal enable is clear drives a low. A pin with a clear output enable also drives a low.
- R10: Writes of every kind except the enable bit go to a staging copy. That copy becomes active at the next line start, or on any cycle while the generator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock. Also the clock-type pin source. |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 3 | Write target: 0 control, 1 line length, 2 toggle point, 3 polarity, 4 pin |
| wr_idx | input | 5 | Point or pin index |
| wr_data | input | 13 | Write data |
| line_sync | input | 1 | External line restart, used in slave mode |
| pin_out | output | 10 | Output pin levels |
| pin_oe | output | 10 | Output pin drive enables |

## Verification
The bench goes after a point whose compare value equals the line length, so that it fires in the wrap cycle. A design that reset the scan before evaluating the match would skip that point. It also places an enabled point after a disabled one: a scan that stepped over the hole would fire the later point. Writes are made in the middle of a line, and a design without the staging copy would bend the waveform before the line ends. Clock-type bits are set on high-numbered pins, where a mux that ignored the pin range would pass the clock through. Random syncs, mode changes and pin writes with indices beyond the pin count are checked against a cycle model of the requirements.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int TPG_NUM_TP     = 32;
    localparam int TPG_NUM_PULSE  = 8;
    localparam int TPG_NUM_PIN    = 10;
    localparam int TPG_NUM_CLKPIN = 5;
    localparam int TPG_CNT_W      = 12;
    localparam int TPG_DATA_W     = TPG_CNT_W + 1;

    typedef enum logic [2:0] {
        WK_CTRL = 3'd0,
        WK_LEN  = 3'd1,
        WK_TP   = 3'd2,
        WK_POL  = 3'd3,
        WK_PIN  = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_st_e;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs #(
    parameter int NUM_TP     = tpg_pkg::TPG_NUM_TP,
    parameter int NUM_PULSE  = tpg_pkg::TPG_NUM_PULSE,
    parameter int NUM_PIN    = tpg_pkg::TPG_NUM_PIN,
    parameter int NUM_CLKPIN = tpg_pkg::TPG_NUM_CLKPIN,
    parameter int CNT_W      = tpg_pkg::TPG_CNT_W,
    parameter int IDX_W      = $clog2(NUM_TP),
    parameter int PSEL_W     = $clog2(NUM_PULSE),
    parameter int DATA_W     = CNT_W + 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [2:0]                            wr_kind,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  commit,
    output logic                                  act_en,
    output logic                                  act_master,
    output logic [CNT_W-1:0]                      act_len,
    output logic [NUM_TP-1:0][CNT_W-1:0]          act_tp_val,
    output logic [NUM_TP-1:0]                     act_tp_en,
    output logic [NUM_TP-1:0][NUM_PULSE-1:0]      act_pol,
    output logic [NUM_PIN-1:0][PSEL_W-1:0]        act_sel,
    output logic [NUM_CLKPIN-1:0]                 act_ck,
    output logic [NUM_PIN-1:0]                    act_oe,
    output logic [NUM_PIN-1:0]                    act_se
);
    import tpg_pkg::*;

    localparam int PIN_IW = $clog2(NUM_PIN);
    localparam int CK_IW  = $clog2(NUM_CLKPIN);
    localparam int TP_EN_BIT = CNT_W;
    localparam int CK_BIT = PSEL_W;
    localparam int OE_BIT = PSEL_W + 1;
    localparam int SE_BIT = PSEL_W + 2;

    logic                             stg_en, stg_master;
    logic [CNT_W-1:0]                 stg_len;
    logic [NUM_TP-1:0][CNT_W-1:0]     stg_tp_val;
    logic [NUM_TP-1:0]                stg_tp_en;
    logic [NUM_TP-1:0][NUM_PULSE-1:0] stg_pol;
    logic [NUM_PIN-1:0][PSEL_W-1:0]   stg_sel;
    logic [NUM_CLKPIN-1:0]            stg_ck;
    logic [NUM_PIN-1:0]               stg_oe, stg_se;

    wire [PIN_IW-1:0] pin_i = wr_idx[PIN_IW-1:0];
    wire [CK_IW-1:0]  ck_i  = wr_idx[CK_IW-1:0];

    // staging copy, written directly by the port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_en     <= 1'b0;
            stg_master <= 1'b0;
            stg_len    <= '0;
            stg_tp_val <= '0;
            stg_tp_en  <= '0;
            stg_pol    <= '0;
            stg_sel    <= '0;
            stg_ck     <= '0;
            stg_oe     <= '0;
            stg_se     <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                WK_CTRL: begin
                    stg_en     <= wr_data[0];
                    stg_master <= wr_data[1];
                end
                WK_LEN: stg_len <= wr_data[CNT_W-1:0];
                WK_TP: if (int'(wr_idx) < NUM_TP) begin
                    stg_tp_val[wr_idx] <= wr_data[CNT_W-1:0];
                    stg_tp_en[wr_idx]  <= wr_data[TP_EN_BIT];
                end
                WK_POL: if (int'(wr_idx) < NUM_TP)
                    stg_pol[wr_idx] <= wr_data[NUM_PULSE-1:0];
                WK_PIN: if (int'(wr_idx) < NUM_PIN) begin
                    stg_sel[pin_i] <= wr_data[PSEL_W-1:0];
                    stg_oe[pin_i]  <= wr_data[OE_BIT];
                    stg_se[pin_i]  <= wr_data[SE_BIT];
                    if (int'(wr_idx) < NUM_CLKPIN)
                        stg_ck[ck_i] <= wr_data[CK_BIT];
                end
                default: ;
            endcase
        end
    end

    // enable acts at once; the rest waits for a commit
    assign act_en = stg_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_master <= 1'b0;
            act_len    <= '0;
            act_tp_val <= '0;
            act_tp_en  <= '0;
            act_pol    <= '0;
            act_sel    <= '0;
            act_ck     <= '0;
            act_oe     <= '0;
            act_se     <= '0;
        end else if (commit) begin
            act_master <= stg_master;
            act_len    <= stg_len;
            act_tp_val <= stg_tp_val;
            act_tp_en  <= stg_tp_en;
            act_pol    <= stg_pol;
            act_sel    <= stg_sel;
            act_ck     <= stg_ck;
            act_oe     <= stg_oe;
            act_se     <= stg_se;
        end
    end
endmodule

// File: rtl/tpg_scan.sv
module tpg_scan #(
    parameter int NUM_TP    = tpg_pkg::TPG_NUM_TP,
    parameter int NUM_PULSE = tpg_pkg::TPG_NUM_PULSE,
    parameter int CNT_W     = tpg_pkg::TPG_CNT_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              master,
    input  logic [CNT_W-1:0]                  len,
    input  logic                              line_sync,
    input  logic [NUM_TP-1:0][CNT_W-1:0]      tp_val,
    input  logic [NUM_TP-1:0]                 tp_en,
    input  logic [NUM_TP-1:0][NUM_PULSE-1:0]  pol,
    output logic [CNT_W-1:0]                  cnt,
    output logic [NUM_PULSE-1:0]              pulses,
    output logic                              line_start,
    output logic                              hit
);
    import tpg_pkg::*;

    localparam int TIDX_W = $clog2(NUM_TP);
    localparam int PTR_W  = $clog2(NUM_TP + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    scan_st_e          state_q, state_d;
    logic [PTR_W-1:0]  ptr_q;
    logic [TIDX_W-1:0] idx, nxt_idx;
    logic              cur_ok, nxt_ok;

    assign idx     = ptr_q[TIDX_W-1:0];
    assign nxt_idx = idx + 1'b1;
    assign cur_ok  = (int'(ptr_q) < NUM_TP) && tp_en[idx];
    assign nxt_ok  = (int'(ptr_q) + 1 < NUM_TP) && tp_en[nxt_idx];

    assign line_start = en && (master ? (cnt == len) : line_sync);
    assign hit = en && (state_q != ST_DONE) && cur_ok && (tp_val[idx] == cnt);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else if (line_start) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SCAN: begin
                    if (!cur_ok || (hit && !nxt_ok))
                        state_d = ST_DONE;
                    else
                        state_d = ST_SCAN;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter, scan pointer and pulse levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            ptr_q  <= '0;
            pulses <= '0;
        end else if (!en) begin
            cnt    <= '0;
            ptr_q  <= '0;
            pulses <= '0;
        end else begin
            if (hit)
                pulses <= pol[idx];
            if (line_start) begin
                cnt   <= '0;
                ptr_q <= '0;
            end else begin
                if (cnt != CNT_MAX)
                    cnt <= cnt + 1'b1;
                if (hit)
                    ptr_q <= ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpg_pinmux.sv
module tpg_pinmux #(
    parameter int NUM_PIN    = tpg_pkg::TPG_NUM_PIN,
    parameter int NUM_CLKPIN = tpg_pkg::TPG_NUM_CLKPIN,
    parameter int NUM_PULSE  = tpg_pkg::TPG_NUM_PULSE,
    parameter int PSEL_W     = $clog2(NUM_PULSE)
) (
    input  logic                           pix_clk,
    input  logic [NUM_PULSE-1:0]           pulses,
    input  logic [NUM_PIN-1:0][PSEL_W-1:0] sel,
    input  logic [NUM_CLKPIN-1:0]          ck,
    input  logic [NUM_PIN-1:0]             oe,
    input  logic [NUM_PIN-1:0]             se,
    output logic [NUM_PIN-1:0]             pin_out,
    output logic [NUM_PIN-1:0]             pin_oe
);
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        logic sig;
        if (p < NUM_CLKPIN) begin : g_clk_capable
            assign sig = ck[p] ? pix_clk : pulses[sel[p]];
        end else begin : g_pulse_only
            assign sig = pulses[sel[p]];
        end
        assign pin_out[p] = oe[p] & se[p] & sig;
        assign pin_oe[p]  = oe[p];
    end
endmodule

// File: rtl/tpg_line_pulse_gen.sv
module tpg_line_pulse_gen #(
    parameter int NUM_TP     = tpg_pkg::TPG_NUM_TP,
    parameter int NUM_PULSE  = tpg_pkg::TPG_NUM_PULSE,
    parameter int NUM_PIN    = tpg_pkg::TPG_NUM_PIN,
    parameter int NUM_CLKPIN = tpg_pkg::TPG_NUM_CLKPIN,
    parameter int CNT_W      = tpg_pkg::TPG_CNT_W,
    localparam int IDX_W     = $clog2(NUM_TP),
    localparam int PSEL_W    = $clog2(NUM_PULSE),
    localparam int DATA_W    = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_kind,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               line_sync,
    output logic [NUM_PIN-1:0] pin_out,
    output logic [NUM_PIN-1:0] pin_oe
);
    logic                             act_en, act_master;
    logic [CNT_W-1:0]                 act_len;
    logic [NUM_TP-1:0][CNT_W-1:0]     act_tp_val;
    logic [NUM_TP-1:0]                act_tp_en;
    logic [NUM_TP-1:0][NUM_PULSE-1:0] act_pol;
    logic [NUM_PIN-1:0][PSEL_W-1:0]   act_sel;
    logic [NUM_CLKPIN-1:0]            act_ck;
    logic [NUM_PIN-1:0]               act_oe, act_se;
    logic [CNT_W-1:0]                 cnt;
    logic [NUM_PULSE-1:0]             pulses;
    logic                             line_start, hit, commit;

    assign commit = !act_en || line_start;

    tpg_regs #(
        .NUM_TP(NUM_TP), .NUM_PULSE(NUM_PULSE), .NUM_PIN(NUM_PIN),
        .NUM_CLKPIN(NUM_CLKPIN), .CNT_W(CNT_W), .IDX_W(IDX_W),
        .PSEL_W(PSEL_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit),
        .act_en(act_en), .act_master(act_master), .act_len(act_len),
        .act_tp_val(act_tp_val), .act_tp_en(act_tp_en), .act_pol(act_pol),
        .act_sel(act_sel), .act_ck(act_ck), .act_oe(act_oe), .act_se(act_se)
    );

    tpg_scan #(
        .NUM_TP(NUM_TP), .NUM_PULSE(NUM_PULSE), .CNT_W(CNT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .en(act_en), .master(act_master),
        .len(act_len), .line_sync(line_sync), .tp_val(act_tp_val),
        .tp_en(act_tp_en), .pol(act_pol), .cnt(cnt), .pulses(pulses),
        .line_start(line_start), .hit(hit)
    );

    tpg_pinmux #(
        .NUM_PIN(NUM_PIN), .NUM_CLKPIN(NUM_CLKPIN),
        .NUM_PULSE(NUM_PULSE), .PSEL_W(PSEL_W)
    ) u_pinmux (
        .pix_clk(clk), .pulses(pulses), .sel(act_sel), .ck(act_ck),
        .oe(act_oe), .se(act_se), .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int NUM_PULSE = tpg_pkg::TPG_NUM_PULSE,
    parameter int NUM_PIN   = tpg_pkg::TPG_NUM_PIN,
    parameter int CNT_W     = tpg_pkg::TPG_CNT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 act_en,
    input logic                 act_master,
    input logic [CNT_W-1:0]     act_len,
    input logic                 line_sync,
    input logic [CNT_W-1:0]     cnt,
    input logic [NUM_PULSE-1:0] pulses,
    input logic                 hit,
    input logic                 commit,
    input logic [NUM_PIN-1:0]   pin_out,
    input logic [NUM_PIN-1:0]   pin_oe
);
    a_r1_idle_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> (pulses == '0 && cnt == '0));

    a_r2_master_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && act_master && cnt == act_len) |=> (cnt == '0));

    a_r3_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !act_master && line_sync) |=> (cnt == '0));

    a_r6_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !hit) |=> $stable(pulses));

    a_r9_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    a_r10_len_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !commit) |=> $stable(act_len));
endmodule

bind tpg_line_pulse_gen tpg_checker #(
    .NUM_PULSE(NUM_PULSE), .NUM_PIN(NUM_PIN), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_master(act_master),
    .act_len(act_len), .line_sync(line_sync), .cnt(cnt), .pulses(pulses),
    .hit(hit), .commit(commit), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_tpg_line_pulse_gen.sv
`timescale 1ns/1ps
module tb_tpg_line_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [4:0]  wr_idx = '0;
    logic [12:0] wr_data = '0;
    logic        line_sync = 1'b0;
    logic [9:0]  pin_out, pin_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tpg_line_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .line_sync(line_sync),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // reference state: staged (s_) and active (a_) settings
    bit        s_en, s_master, a_master;
    bit [11:0] s_len, a_len;
    bit [11:0] s_tpv [32];
    bit [11:0] a_tpv [32];
    bit        s_tpe [32];
    bit        a_tpe [32];
    bit [7:0]  s_pol [32];
    bit [7:0]  a_pol [32];
    bit [2:0]  s_sel [10];
    bit [2:0]  a_sel [10];
    bit        s_ck [5];
    bit        a_ck [5];
    bit        s_oe [10];
    bit        a_oe [10];
    bit        s_se [10];
    bit        a_se [10];
    int        m_cnt, m_ptr;
    bit [7:0]  m_pul;

    function automatic bit exp_pin(int p, bit clkv);
        if (!(a_oe[p] && a_se[p])) return 1'b0;
        if (p < 5 && a_ck[p]) return clkv;
        return m_pul[a_sel[p]];
    endfunction

    function automatic void model_step(bit sync, bit we, bit [2:0] k, bit [4:0] i, bit [12:0] d);
        bit ls, commit, h;
        ls = s_en && (a_master ? (m_cnt == int'(a_len)) : sync);
        commit = !s_en || ls;
        if (!s_en) begin
            m_cnt = 0; m_ptr = 0; m_pul = '0;
        end else begin
            h = (m_ptr < 32) && a_tpe[m_ptr] && (int'(a_tpv[m_ptr]) == m_cnt);
            if (h) m_pul = a_pol[m_ptr];
            if (ls) begin
                m_cnt = 0; m_ptr = 0;
            end else begin
                if (m_cnt != 4095) m_cnt++;
                if (h) m_ptr++;
            end
        end
        if (commit) begin
            a_master = s_master; a_len = s_len;
            for (int t = 0; t < 32; t++) begin
                a_tpv[t] = s_tpv[t]; a_tpe[t] = s_tpe[t]; a_pol[t] = s_pol[t];
            end
            for (int p = 0; p < 10; p++) begin
                a_sel[p] = s_sel[p]; a_oe[p] = s_oe[p]; a_se[p] = s_se[p];
                if (p < 5) a_ck[p] = s_ck[p];
            end
        end
        if (we) begin
            case (k)
                3'd0: begin s_en = d[0]; s_master = d[1]; end
                3'd1: s_len = d[11:0];
                3'd2: begin s_tpv[i] = d[11:0]; s_tpe[i] = d[12]; end
                3'd3: s_pol[i] = d[7:0];
                3'd4: if (i < 10) begin
                    s_sel[i] = d[2:0]; s_oe[i] = d[4]; s_se[i] = d[5];
                    if (i < 5) s_ck[i] = d[3];
                end
                default: ;
            endcase
        end
    endfunction

    task automatic check_pins(string tag, bit clkv);
        bit [9:0] eo, ee;
        for (int p = 0; p < 10; p++) begin
            ee[p] = exp_pin(p, clkv);
            eo[p] = a_oe[p];
        end
        checks++;
        if (pin_out !== ee || pin_oe !== eo) begin
            failures++;
            $display("FAIL %s: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
                     tag, pin_out, pin_oe, ee, eo);
        end
    endtask

    task automatic cycle(string tag, bit sync, bit we, bit [2:0] k, bit [4:0] i, bit [12:0] d);
        @(negedge clk);
        check_pins(tag, 1'b0);
        line_sync = sync; wr_en = we; wr_kind = k; wr_idx = i; wr_data = d;
        model_step(sync, we, k, i, d);
        @(posedge clk);
        #1;
        check_pins(tag, 1'b1);
    endtask

    task automatic idle(string tag, int n);
        for (int c = 0; c < n; c++) cycle(tag, 1'b0, 1'b0, 3'd0, 5'd0, 13'd0);
    endtask

    task automatic wr(string tag, bit [2:0] k, bit [4:0] i, bit [12:0] d);
        cycle(tag, 1'b0, 1'b1, k, i, d);
    endtask

    function automatic bit [12:0] tp_word(bit e, int v);
        return {e, 12'(v)};
    endfunction

    function automatic bit [12:0] pin_word(bit se, bit oe, bit ck, int sel);
        return {7'd0, se, oe, ck, 3'(sel)};
    endfunction

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R9: reset state, nothing driven
        checks++;
        if (pin_out !== 10'd0 || pin_oe !== 10'd0) begin
            failures++;
            $display("FAIL R9 reset: pin_out=%b pin_oe=%b expected 0 0", pin_out, pin_oe);
        end
        rst_n = 1'b1;

        // R10: writes while disabled become active at once
        wr("R4 setup", 3'd2, 5'd0, tp_word(1, 2));
        wr("R4 setup", 3'd2, 5'd1, tp_word(1, 5));
        wr("R4 setup", 3'd2, 5'd2, tp_word(1, 6));
        wr("R4 setup", 3'd2, 5'd3, tp_word(1, 11)); // fires in wrap cycle
        wr("R4 setup", 3'd2, 5'd4, tp_word(0, 8));  // disabled: ends scan
        wr("R4 setup", 3'd2, 5'd5, tp_word(1, 1));  // behind a hole: never fires
        wr("R6 setup", 3'd3, 5'd0, 13'h055);
        wr("R6 setup", 3'd3, 5'd1, 13'h0AA);
        wr("R6 setup", 3'd3, 5'd2, 13'h00F);
        wr("R6 setup", 3'd3, 5'd3, 13'h033);
        wr("R6 setup", 3'd3, 5'd5, 13'h0FF);
        for (int p = 0; p < 8; p++) wr("R7 setup", 3'd4, 5'(p), pin_word(1, 1, 0, p));
        wr("R9 setup", 3'd4, 5'd8, pin_word(0, 1, 0, 0));  // output enable only
        wr("R8 setup", 3'd4, 5'd9, pin_word(1, 1, 1, 1));  // clock bit ignored here
        wr("R7 setup", 3'd4, 5'd12, pin_word(1, 1, 1, 3)); // index beyond pins
        wr("R2 setup", 3'd1, 5'd0, 13'd11);
        idle("R1 disabled idle", 4);

        // R2/R5/R6: master mode lines
        wr("R2 enable", 3'd0, 5'd0, 13'd3);
        idle("R2/R4/R5/R6 master lines", 40);

        // R10: mid-line writes wait for the line start
        wr("R10 midline len", 3'd1, 5'd0, 13'd7);
        wr("R10 midline pol", 3'd3, 5'd0, 13'h0C3);
        wr("R10 midline pin", 3'd4, 5'd0, pin_word(1, 1, 0, 7));
        idle("R10 shadow", 30);

        // R8: clock-type pin
        wr("R8 clock pin", 3'd4, 5'd2, pin_word(1, 1, 1, 2));
        idle("R8 clock pin", 20);
        wr("R9 se off", 3'd4, 5'd2, pin_word(0, 1, 1, 2));
        idle("R9 gating", 20);

        // R1: disable clears pulses immediately
        wr("R1 disable", 3'd0, 5'd0, 13'd0);
        idle("R1 disabled idle", 10);

        // R3: slave mode with syncs
        wr("R3 slave", 3'd0, 5'd0, 13'd1);
        for (int c = 0; c < 300; c++)
            cycle("R3 slave sync", ($urandom % 13) == 0, 1'b0, 3'd0, 5'd0, 13'd0);

        // mixed random traffic
        for (int c = 0; c < 2500; c++) begin
            bit [2:0]  k;
            bit [4:0]  i;
            bit [12:0] d;
            bit        we;
            we = ($urandom % 4) == 0;
            k  = 3'($urandom % 5);
            i  = 5'($urandom % 32);
            case (k)
                3'd0: d = {11'd0, 1'($urandom % 2), 1'(($urandom % 10) != 0)};
                3'd1: d = 13'(3 + $urandom % 18);
                3'd2: d = tp_word(($urandom % 4) != 0, $urandom % 24);
                3'd3: d = 13'($urandom % 256);
                default: d = 13'($urandom % 64);
            endcase
            cycle("R5/R7/R10 random", ($urandom % 11) == 0, we, k, i, d);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule